// File: doc/BRIEF.md
# Sideband Message Mailbox Controller

This block lets a host issue one sideband message at a time to an endpoint on an on-chip fabric and collect the reply. The host sees a small window of configuration registers, which it can access as bytes, halfwords or dwords. It programs a destination port and register offset, a data word, a routing word (byte enables, BAR index and function ID) and an extended address. It then launches the message by writing the control/status halfword with its busy bit set.

The controller drives a valid/ready request onto the fabric carrying every programmed field. The request stays on the fabric until it is accepted. A non-posted message then waits for a reply. The reply's opcode, posted flag and 2-bit completion status are written back into the control/status halfword. A reply that carries data also overwrites the data register. A posted message completes as soon as it is accepted. A message whose reply does not arrive within a host-supplied number of cycles completes with a timeout code.

A hide byte makes the whole function appear absent: all reads return ones and all register writes are dropped, except writes to the hide byte. Reset leaves the function hidden.

Top module: `sbmbox_top`

## Requirements
- R1: After reset the function is hidden (hide byte = 0x01), so every read returns 0xFFFFFFFF and `req_valid` is 0. Once the hide byte is written to 0, every register reads zero and busy reads 0.
- R2: The host port has three access sizes, set by `cfg_size`: 0 = byte, 1 = halfword, 2 or 3 = dword. Data is right-justified and accesses are naturally aligned. The dword at 0xD0 holds the port in bits 31:24 and the register offset in bits 15:0. The data register is the dword at 0xD4 and the extended address is the dword at 0xDC. Unimplemented bits and offsets read zero.
- R3: The control/status halfword at 0xD8 has this layout: bit 0 busy (read-only), bits 2:1 completion status, bits 6:3 zero, bit 7 posted, bits 15:8 opcode. The routing halfword at 0xDA has this layout: bits 7:0 function ID, bits 10:8 BAR index, bit 11 zero, bits 15:12 byte enables.
- R4: A write that touches byte 0xD8 with bit 0 set, while the function is idle, raises `req_valid` by the next cycle. The request carries the programmed fields, including the opcode and posted flag from that same write, and busy then reads 1.
- R5: While `req_valid` is high and `req_ready` is low, the request and all of its fields stay unchanged.
- R6: After a non-posted request is accepted, an `rsp_valid` pulse clears busy. It loads the reply's opcode, posted flag and status into the control/status halfword. It overwrites the data register only when `rsp_data_vld` is 1.
- R7: A posted request completes in the cycle it is accepted. Busy clears, the status field becomes 0, and the opcode, posted flag and data stay unchanged.
- R8: A non-posted request with no reply completes `tmo_limit` cycles after acceptance (`tmo_limit` >= 1). Busy clears and the status field becomes 3, the timeout code.
- R9: While busy, host writes to the address, data, routing, extended-address and control/status registers are ignored, and a second launch is ignored.
- R10: While the hide byte (byte 0xE1) is nonzero, all reads return 0xFFFFFFFF and writes to any register other than the hide byte are ignored, including launches. The hide byte stays writable, and writing 0 to it restores normal access.
- R11: A write to the control/status halfword with bit 0 clear stores the opcode, posted and status fields but starts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Host write strobe |
| cfg_addr | input | 8 | Host byte address |
| cfg_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 dword |
| cfg_wdata | input | 32 | Right-justified write data |
| cfg_rdata | output | 32 | Right-justified read data, combinational from address and size |
| tmo_limit | input | TMO_W | Reply timeout in cycles |
| req_valid | output | 1 | Fabric request valid |
| req_ready | input | 1 | Fabric accepts request |
| req_port | output | 8 | Destination port ID |
| req_offset | output | 16 | Register offset at the endpoint |
| req_opcode | output | 8 | Message opcode |
| req_posted | output | 1 | Posted message, no reply expected |
| req_data | output | 32 | Message data |
| req_be | output | 4 | Byte enables |
| req_bar | output | 3 | BAR index |
| req_fid | output | 8 | Function ID |
| req_eaddr | output | 32 | Extended address |
| rsp_valid | input | 1 | Reply strobe |
| rsp_status | input | 2 | Reply completion status |
| rsp_opcode | input | 8 | Reply opcode |
| rsp_posted | input | 1 | Reply posted flag |
| rsp_data_vld | input | 1 | Reply carries data |
| rsp_data | input | 32 | Reply data |

## Verification
The message path is exercised with four outcome kinds, each with different field values:
- a reply that carries data,
- a reply without data,
- a posted message,
- a timeout.

Together these show which fields of the control/status halfword and the data register each completion type may change. Every request is held against a stalled `req_ready` first, which separates holding a request from re-launching it. Further cases drive writes during a flight, writes while hidden, and halfword and byte accesses to the lanes of a shared dword. These show whether freezing, masking and lane selection act per register or across the whole window.

// File: rtl/sbmbox_pkg.sv
package sbmbox_pkg;

    // dword indices (byte address >> 2) of the register window
    localparam logic [5:0] DW_ADDR  = 6'h34;
    localparam logic [5:0] DW_DATA  = 6'h35;
    localparam logic [5:0] DW_STAT  = 6'h36;
    localparam logic [5:0] DW_EADDR = 6'h37;
    localparam logic [5:0] DW_HIDE  = 6'h38;

    localparam int         HIDE_LANE  = 1;
    localparam logic [1:0] TMO_CODE   = 2'b11;
    localparam logic [7:0] HIDE_RESET = 8'h01;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_WAIT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [7:0]  port;
        logic [15:0] roff;
        logic [31:0] data;
        logic [7:0]  opc;
        logic        posted;
        logic [1:0]  stat;
        logic [3:0]  be;
        logic [2:0]  bar;
        logic [7:0]  fid;
        logic [31:0] eaddr;
        logic [7:0]  hide;
    } mbx_regs_t;

endpackage

// File: rtl/sbmbox_engine.sv
module sbmbox_engine
    import sbmbox_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             posted,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_status,
    input  logic             rsp_data_vld,
    output logic             busy,
    output logic             req_valid,
    output logic             done,
    output logic [1:0]       done_stat,
    output logic             done_hdr_we,
    output logic             done_data_we
);

    typedef struct packed {
        eng_state_e       st;
        logic [TMO_W-1:0] cnt;
    } eng_t;

    eng_t e_d, e_q;

    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    always_comb begin
        e_d          = e_q;
        done         = 1'b0;
        done_stat    = 2'b00;
        done_hdr_we  = 1'b0;
        done_data_we = 1'b0;
        case (e_q.st)
            ENG_IDLE: begin
                if (launch) begin
                    e_d.st = ENG_REQ;
                end
            end
            ENG_REQ: begin
                if (req_ready) begin
                    if (posted) begin
                        e_d.st    = ENG_IDLE;
                        done      = 1'b1;
                        done_stat = 2'b00;
                    end else begin
                        e_d.st  = ENG_WAIT;
                        e_d.cnt = '0;
                    end
                end
            end
            ENG_WAIT: begin
                if (rsp_valid) begin
                    e_d.st       = ENG_IDLE;
                    done         = 1'b1;
                    done_stat    = rsp_status;
                    done_hdr_we  = 1'b1;
                    done_data_we = rsp_data_vld;
                end else if (e_q.cnt == tmo_limit - ONE) begin
                    e_d.st    = ENG_IDLE;
                    done      = 1'b1;
                    done_stat = TMO_CODE;
                end else begin
                    e_d.cnt = e_q.cnt + ONE;
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q.st  <= ENG_IDLE;
            e_q.cnt <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy      = (e_q.st != ENG_IDLE);
    assign req_valid = (e_q.st == ENG_REQ);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid); // R5

    AST_POSTED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && posted |=> !busy); // R7

    AST_REPLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ENG_WAIT) && rsp_valid |=> !busy); // R6

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ENG_WAIT) && (tmo_limit != '0) && $stable(tmo_limit)
        |-> e_q.cnt < tmo_limit); // R8

endmodule

// File: rtl/sbmbox_regs.sv
module sbmbox_regs
    import sbmbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [1:0]  cfg_size,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        busy,
    input  logic        done,
    input  logic [1:0]  done_stat,
    input  logic        done_hdr_we,
    input  logic        done_data_we,
    input  logic [7:0]  rsp_opcode,
    input  logic        rsp_posted,
    input  logic [31:0] rsp_data,
    output logic        launch,
    output mbx_regs_t   regs
);

    mbx_regs_t r_d, r_q;

    logic [5:0]  dw;
    logic [3:0]  lane_base;
    logic [3:0]  lane;
    logic [31:0] w;
    logic        wr_ok;
    logic [31:0] rd_dw;
    logic [31:0] rd_sh;

    function automatic logic [31:0] merge32(input logic [31:0] old,
                                            input logic [31:0] nw,
                                            input logic [3:0]  ln);
        logic [31:0] r;
        r = old;
        for (int i = 0; i < 4; i++) begin
            if (ln[i]) r[8*i +: 8] = nw[8*i +: 8];
        end
        return r;
    endfunction

    always_comb begin
        dw = cfg_addr[7:2];
        case (cfg_size)
            2'd0:    lane_base = 4'b0001;
            2'd1:    lane_base = 4'b0011;
            default: lane_base = 4'b1111;
        endcase
        lane = lane_base << cfg_addr[1:0];
        w    = cfg_wdata << {cfg_addr[1:0], 3'b000};
    end

    // next-state of the register file
    always_comb begin
        r_d    = r_q;
        launch = 1'b0;
        wr_ok  = cfg_wr && ((r_q.hide == 8'h00) || (dw == DW_HIDE));
        if (wr_ok) begin
            case (dw)
                DW_ADDR: if (!busy) begin
                    if (lane[0]) r_d.roff[7:0]  = w[7:0];
                    if (lane[1]) r_d.roff[15:8] = w[15:8];
                    if (lane[3]) r_d.port       = w[31:24];
                end
                DW_DATA: if (!busy) begin
                    r_d.data = merge32(r_q.data, w, lane);
                end
                DW_STAT: if (!busy) begin
                    if (lane[0]) begin
                        r_d.posted = w[7];
                        r_d.stat   = w[2:1];
                        launch     = w[0];
                    end
                    if (lane[1]) r_d.opc = w[15:8];
                    if (lane[2]) r_d.fid = w[23:16];
                    if (lane[3]) begin
                        r_d.be  = w[31:28];
                        r_d.bar = w[26:24];
                    end
                end
                DW_EADDR: if (!busy) begin
                    r_d.eaddr = merge32(r_q.eaddr, w, lane);
                end
                DW_HIDE: begin
                    if (lane[HIDE_LANE]) r_d.hide = w[8*HIDE_LANE +: 8];
                end
                default: ;
            endcase
        end
        if (done) begin
            r_d.stat = done_stat;
            if (done_hdr_we) begin
                r_d.opc    = rsp_opcode;
                r_d.posted = rsp_posted;
            end
            if (done_data_we) r_d.data = rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.hide <= HIDE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // read path
    always_comb begin
        case (dw)
            DW_ADDR:  rd_dw = {r_q.port, 8'h00, r_q.roff};
            DW_DATA:  rd_dw = r_q.data;
            DW_STAT:  rd_dw = {r_q.be, 1'b0, r_q.bar, r_q.fid,
                               r_q.opc, r_q.posted, 4'b0000, r_q.stat, busy};
            DW_EADDR: rd_dw = r_q.eaddr;
            DW_HIDE:  rd_dw = 32'(r_q.hide) << (8 * HIDE_LANE);
            default:  rd_dw = 32'h0;
        endcase
        rd_sh = rd_dw >> {cfg_addr[1:0], 3'b000};
        case (cfg_size)
            2'd0:    cfg_rdata = {24'h0, rd_sh[7:0]};
            2'd1:    cfg_rdata = {16'h0, rd_sh[15:0]};
            default: cfg_rdata = rd_sh;
        endcase
        if (r_q.hide != 8'h00) cfg_rdata = '1;
    end

    assign regs = r_q;

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy); // R4

    AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_wr |=> $stable(r_q.port) && $stable(r_q.roff) &&
        $stable(r_q.be) && $stable(r_q.bar) && $stable(r_q.fid) &&
        $stable(r_q.eaddr)); // R9

    AST_FROZEN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hide != 8'h00) && cfg_wr && (dw != DW_HIDE)
        |=> $stable(r_q.port) && $stable(r_q.roff) && $stable(r_q.be) &&
        $stable(r_q.bar) && $stable(r_q.fid) && $stable(r_q.eaddr)); // R10

    AST_HIDDEN_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hide != 8'h00) && !busy |=> !busy); // R10

endmodule

// File: rtl/sbmbox_top.sv
module sbmbox_top
    import sbmbox_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [1:0]       cfg_size,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [7:0]       req_port,
    output logic [15:0]      req_offset,
    output logic [7:0]       req_opcode,
    output logic             req_posted,
    output logic [31:0]      req_data,
    output logic [3:0]       req_be,
    output logic [2:0]       req_bar,
    output logic [7:0]       req_fid,
    output logic [31:0]      req_eaddr,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_status,
    input  logic [7:0]       rsp_opcode,
    input  logic             rsp_posted,
    input  logic             rsp_data_vld,
    input  logic [31:0]      rsp_data
);

    mbx_regs_t  regs;
    logic       launch;
    logic       busy;
    logic       done;
    logic [1:0] done_stat;
    logic       done_hdr_we;
    logic       done_data_we;

    sbmbox_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_size     (cfg_size),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .busy         (busy),
        .done         (done),
        .done_stat    (done_stat),
        .done_hdr_we  (done_hdr_we),
        .done_data_we (done_data_we),
        .rsp_opcode   (rsp_opcode),
        .rsp_posted   (rsp_posted),
        .rsp_data     (rsp_data),
        .launch       (launch),
        .regs         (regs)
    );

    sbmbox_engine #(.TMO_W(TMO_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .posted       (regs.posted),
        .tmo_limit    (tmo_limit),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .rsp_data_vld (rsp_data_vld),
        .busy         (busy),
        .req_valid    (req_valid),
        .done         (done),
        .done_stat    (done_stat),
        .done_hdr_we  (done_hdr_we),
        .done_data_we (done_data_we)
    );

    assign req_port   = regs.port;
    assign req_offset = regs.roff;
    assign req_opcode = regs.opc;
    assign req_posted = regs.posted;
    assign req_data   = regs.data;
    assign req_be     = regs.be;
    assign req_bar    = regs.bar;
    assign req_fid    = regs.fid;
    assign req_eaddr  = regs.eaddr;

    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(req_port) && $stable(req_offset) &&
        $stable(req_opcode) && $stable(req_data) && $stable(req_eaddr) &&
        $stable(req_be) && $stable(req_fid)); // R5

endmodule

// File: tb/sbmbox_top_bench.sv
module sbmbox_top_bench;

    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_addr = 8'h0;
    logic [1:0]       cfg_size = 2'd2;
    logic [31:0]      cfg_wdata = 32'h0;
    logic [31:0]      cfg_rdata;
    logic [TMO_W-1:0] tmo_limit = 16'd5;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic [7:0]       req_port;
    logic [15:0]      req_offset;
    logic [7:0]       req_opcode;
    logic             req_posted;
    logic [31:0]      req_data;
    logic [3:0]       req_be;
    logic [2:0]       req_bar;
    logic [7:0]       req_fid;
    logic [31:0]      req_eaddr;
    logic             rsp_valid = 1'b0;
    logic [1:0]       rsp_status = 2'b0;
    logic [7:0]       rsp_opcode = 8'h0;
    logic             rsp_posted = 1'b0;
    logic             rsp_data_vld = 1'b0;
    logic [31:0]      rsp_data = 32'h0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sbmbox_top #(.TMO_W(TMO_W)) u_sbmbox_top (.*);

    // kind: 0 reply with data, 1 reply without data, 2 posted, 3 timeout
    typedef struct packed {
        logic [7:0]  port;
        logic [15:0] off;
        logic [7:0]  opc;
        logic        post;
        logic [31:0] data;
        logic [3:0]  be;
        logic [2:0]  bar;
        logic [7:0]  fid;
        logic [31:0] ea;
        logic [1:0]  kind;
        logic [1:0]  rstat;
        logic [7:0]  ropc;
        logic        rpost;
        logic [31:0] rdata;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'h12, 16'h0040, 8'h06, 1'b0, 32'h00000000, 4'hF, 3'd0, 8'h00,
          32'h00000000, 2'd0, 2'd0, 8'h20, 1'b0, 32'hDEADBEEF},
        '{8'hA5, 16'h1234, 8'h07, 1'b0, 32'h11223344, 4'h3, 3'd2, 8'h10,
          32'h00000001, 2'd1, 2'd1, 8'h21, 1'b1, 32'hFFFF0000},
        '{8'h3C, 16'hFFFF, 8'h01, 1'b1, 32'hCAFEF00D, 4'h8, 3'd7, 8'hFF,
          32'hFFFFFFFF, 2'd2, 2'd0, 8'h00, 1'b0, 32'h00000000},
        '{8'h01, 16'h0002, 8'h00, 1'b0, 32'h5555AAAA, 4'h1, 3'd1, 8'h03,
          32'h00000100, 2'd3, 2'd0, 8'h00, 1'b0, 32'h00000000},
        '{8'hFE, 16'h8000, 8'h10, 1'b0, 32'h0F0F0F0F, 4'hC, 3'd4, 8'h80,
          32'h0000ABCD, 2'd0, 2'd2, 8'hC0, 1'b0, 32'h01234567}
    };

    vec_t        cv;
    logic [31:0] v;

    task automatic chk(input string tag, input logic [191:0] got,
                       input logic [191:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s,
                      input logic [31:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_size  = s;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s,
                      output logic [31:0] val);
        cfg_addr = a;
        cfg_size = s;
        #1;
        val = cfg_rdata;
    endtask

    task automatic accept();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic reply(input logic [1:0] st, input logic [7:0] op,
                         input logic po, input logic dv, input logic [31:0] d);
        rsp_valid    = 1'b1;
        rsp_status   = st;
        rsp_opcode   = op;
        rsp_posted   = po;
        rsp_data_vld = dv;
        rsp_data     = d;
        @(negedge clk);
        rsp_valid    = 1'b0;
    endtask

    function automatic logic [112:0] req_bus();
        return {req_valid, req_port, req_offset, req_opcode, req_posted,
                req_data, req_be, req_bar, req_fid, req_eaddr};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // ---------------- reset (R1)
        repeat (3) step();
        rd(8'hD0, 2'd2, v);
        chk("R1 hidden during reset", v, 32'hFFFFFFFF);
        rst_n = 1'b1;
        step();
        rd(8'hD4, 2'd2, v);
        chk("R1 hidden after reset", v, 32'hFFFFFFFF);
        chk("R1 no request after reset", req_valid, 1'b0);
        wr(8'hE1, 2'd0, 32'h0);
        rd(8'hD0, 2'd2, v);  chk("R1 addr zero", v, 0);
        rd(8'hD4, 2'd2, v);  chk("R1 data zero", v, 0);
        rd(8'hD8, 2'd2, v);  chk("R1 status/routing zero, busy 0", v, 0);
        rd(8'hDC, 2'd2, v);  chk("R1 eaddr zero", v, 0);
        rd(8'hE0, 2'd2, v);  chk("R1 hide byte zero", v, 0);

        // ---------------- layout and access sizes (R2, R3, R11)
        wr(8'hD0, 2'd2, 32'hABFF1234);
        rd(8'hD0, 2'd2, v);  chk("R2 addr unused lane reads zero", v, 32'hAB001234);
        wr(8'hD3, 2'd0, 32'h5C);
        rd(8'hD0, 2'd2, v);  chk("R2 byte write to port", v, 32'h5C001234);
        wr(8'hD0, 2'd1, 32'hBEEF);
        rd(8'hD0, 2'd2, v);  chk("R2 halfword write to offset", v, 32'h5C00BEEF);
        rd(8'hD3, 2'd0, v);  chk("R2 byte read of port", v, 32'h5C);
        wr(8'hD4, 2'd2, 32'h01020304);
        wr(8'hD6, 2'd1, 32'hA1B2);
        rd(8'hD4, 2'd2, v);  chk("R2 data upper halfword", v, 32'hA1B20304);
        rd(8'hC0, 2'd2, v);  chk("R2 unmapped offset zero", v, 0);
        wr(8'hDA, 2'd1, 32'hFFFF);
        rd(8'hDA, 2'd1, v);  chk("R3 routing reserved bit zero", v, 32'hF7FF);
        wr(8'hD8, 2'd1, 32'hFFFE);
        rd(8'hD8, 2'd1, v);  chk("R3 status layout", v, 32'hFF86);
        chk("R11 no launch without busy bit", req_valid, 1'b0);
        step();
        chk("R11 still idle", req_valid, 1'b0);
        wr(8'hD8, 2'd1, 32'h0000);

        // ---------------- vector table (R4..R8)
        for (int i = 0; i < 5; i++) begin
            cv = VEC[i];
            wr(8'hD0, 2'd2, {cv.port, 8'h00, cv.off});
            wr(8'hD4, 2'd2, cv.data);
            wr(8'hDA, 2'd1, {16'h0, cv.be, 1'b0, cv.bar, cv.fid});
            wr(8'hDC, 2'd2, cv.ea);
            wr(8'hD8, 2'd1, {16'h0, cv.opc, cv.post, 4'b0, 2'b00, 1'b1});
            chk("R4 request fields", req_bus(),
                {1'b1, cv.port, cv.off, cv.opc, cv.post, cv.data, cv.be,
                 cv.bar, cv.fid, cv.ea});
            rd(8'hD8, 2'd1, v);
            chk("R4 busy reads 1", v[0], 1'b1);
            step();
            step();
            chk("R5 request held while stalled", req_bus(),
                {1'b1, cv.port, cv.off, cv.opc, cv.post, cv.data, cv.be,
                 cv.bar, cv.fid, cv.ea});
            accept();
            case (cv.kind)
                2'd2: begin
                    rd(8'hD8, 2'd1, v);
                    chk("R7 posted completes on accept", v,
                        {16'h0, cv.opc, 1'b1, 4'b0, 2'b00, 1'b0});
                    rd(8'hD4, 2'd2, v);
                    chk("R7 posted keeps data", v, cv.data);
                end
                2'd3: begin
                    repeat (4) step();
                    rd(8'hD8, 2'd1, v);
                    chk("R8 busy before limit", v[0], 1'b1);
                    step();
                    rd(8'hD8, 2'd1, v);
                    chk("R8 timeout status", v,
                        {16'h0, cv.opc, 1'b0, 4'b0, 2'b11, 1'b0});
                    rd(8'hD4, 2'd2, v);
                    chk("R8 timeout keeps data", v, cv.data);
                end
                default: begin
                    step();
                    chk("R6 no request while waiting", req_valid, 1'b0);
                    reply(cv.rstat, cv.ropc, cv.rpost, (cv.kind == 2'd0), cv.rdata);
                    rd(8'hD8, 2'd1, v);
                    chk("R6 reply header", v,
                        {16'h0, cv.ropc, cv.rpost, 4'b0, cv.rstat, 1'b0});
                    rd(8'hD4, 2'd2, v);
                    chk("R6 reply data", v,
                        (cv.kind == 2'd0) ? cv.rdata : cv.data);
                end
            endcase
        end

        // ---------------- writes ignored while busy (R9)
        wr(8'hD0, 2'd2, 32'h44000444);
        wr(8'hD4, 2'd2, 32'h000000D9);
        wr(8'hDA, 2'd1, 32'hF005);
        wr(8'hDC, 2'd2, 32'h00000ABC);
        wr(8'hD8, 2'd1, 32'h0B01);
        wr(8'hD0, 2'd2, 32'h99999999);
        wr(8'hD4, 2'd2, 32'h12345678);
        wr(8'hDA, 2'd1, 32'hFFFF);
        wr(8'hDC, 2'd2, 32'h00000001);
        wr(8'hD8, 2'd1, 32'hEE81);
        chk("R9 request unchanged by writes in flight", req_bus(),
            {1'b1, 8'h44, 16'h0444, 8'h0B, 1'b0, 32'h000000D9, 4'hF, 3'd0,
             8'h05, 32'h00000ABC});
        accept();
        reply(2'b00, 8'h0B, 1'b0, 1'b0, 32'h0);
        rd(8'hD0, 2'd2, v);  chk("R9 addr kept", v, 32'h44000444);
        rd(8'hD4, 2'd2, v);  chk("R9 data kept", v, 32'h000000D9);
        rd(8'hDA, 2'd1, v);  chk("R9 routing kept", v, 32'hF005);
        rd(8'hDC, 2'd2, v);  chk("R9 eaddr kept", v, 32'h00000ABC);
        step();
        chk("R9 second launch ignored", req_valid, 1'b0);

        // ---------------- hide control (R10)
        wr(8'hE1, 2'd0, 32'h07);
        rd(8'hD4, 2'd2, v);  chk("R10 hidden read all ones", v, 32'hFFFFFFFF);
        rd(8'hD9, 2'd0, v);  chk("R10 hidden byte read all ones", v, 32'hFFFFFFFF);
        wr(8'hD0, 2'd2, 32'h11111111);
        wr(8'hD8, 2'd1, 32'h3301);
        chk("R10 hidden launch ignored", req_valid, 1'b0);
        step();
        chk("R10 still no request", req_valid, 1'b0);
        wr(8'hE0, 2'd1, 32'h0000);
        rd(8'hE0, 2'd2, v);  chk("R10 hide byte cleared", v, 0);
        rd(8'hD0, 2'd2, v);  chk("R10 hidden write ignored", v, 32'h44000444);
        rd(8'hD8, 2'd1, v);  chk("R10 status untouched while hidden", v, 32'h0B00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule